// File: doc/BRIEF.md
# Three-Layer View Compositor

The block assembles a progressive output raster of 1920×1080 pixels, 24 bits each, from three pixel streams. The background layer covers the whole screen. The first and second video layers are placed on top of it. Each input is a valid/ready stream that flags the first word of each frame. The output is a valid/ready stream that flags the first pixel of a frame and the last pixel of each line.

Two select inputs pick one of three views. The thumbnail view shows both video layers as 640×360 tiles side by side over the background. The first-layer view shows layer 1 alone, filling the screen. The second-layer view puts layer 2 at the top-left corner at a size given per frame, with the background visible around it.

Each output pixel takes its value from the topmost layer whose rectangle covers it. Layer 2 is on top, then layer 1, then the background, and every covered pixel is opaque. A video layer's input is read only at the pixels it covers. A layer that is hidden in the current view is drained so that its source never stalls. The view and the layer-2 size are captured at the first pixel of each frame, so a frame never mixes two views.

Top module: `view_compositor`

## Requirements
- R1: Each output frame is SCR_W×SCR_H pixels in row-major order. `out_sof` is 1 only on pixel (0,0) and `out_eol` is 1 only on pixels with x = SCR_W-1. While reset is high and in the cycle after it, `out_valid` is 0.
- R2: With `sel_single`=0 (thumbnail view), layer 1 fills x in [TILE1_X, TILE1_X+TILE_W), y in [TILE_Y, TILE_Y+TILE_H), and layer 2 fills x in [TILE2_X, TILE2_X+TILE_W) over the same rows. Each tile takes its words in row-major order from its own frame, and every other pixel comes from the background.
- R3: With `sel_single`=1 and `sel_pick2`=0, every output pixel comes from layer 1 in row-major order. During that frame, `l2_ready` is 1 and the layer-2 words are discarded.
- R4: With `sel_single`=1 and `sel_pick2`=1, layer 2 fills x in [0,w), y in [0,h), where w×h is the captured layer-2 size and words are taken in row-major order. The background shows everywhere else. During that frame, layer 1 is drained and not shown.
- R5: One background word is consumed per output pixel in every view. A shown video layer is consumed only at pixels inside its rectangle, so in the thumbnail view `l1_ready` and `l2_ready` are 0 at pixel (0,0).
- R6: At the first pixel a shown layer covers in a frame (the background's is (0,0)), input words whose start-of-frame flag is 0 are accepted and discarded until a flagged word arrives. That flagged word becomes the pixel.
- R7: The view selects and the layer-2 size are captured when pixel (0,0) of a frame is taken. A change made during a frame first applies to the next frame.
- R8: While `out_ready` is 0, `out_valid` and `out_data` hold. A required input that is not valid delays the output, and no pixel is lost or repeated.
- R9: A layer-2 width or height of 0 is treated as 1. A value above the screen size is limited to the screen size. The size may differ from frame to frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_single | input | 1 | 0: thumbnail view; 1: a single layer is shown |
| sel_pick2 | input | 1 | In single view, 0 shows layer 1 and 1 shows layer 2 |
| l2_width | input | 16 | Layer-2 width for the second-layer view |
| l2_height | input | 16 | Layer-2 height for the second-layer view |
| bg_valid | input | 1 | Background word valid |
| bg_ready | output | 1 | Background word accepted |
| bg_sof | input | 1 | Background word is the first of its frame |
| bg_data | input | PIX_W | Background pixel |
| l1_valid | input | 1 | Layer-1 word valid |
| l1_ready | output | 1 | Layer-1 word accepted |
| l1_sof | input | 1 | Layer-1 word is the first of its frame |
| l1_data | input | PIX_W | Layer-1 pixel |
| l2_valid | input | 1 | Layer-2 word valid |
| l2_ready | output | 1 | Layer-2 word accepted |
| l2_sof | input | 1 | Layer-2 word is the first of its frame |
| l2_data | input | PIX_W | Layer-2 pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted downstream |
| out_sof | output | 1 | Output pixel is (0,0) |
| out_eol | output | 1 | Output pixel ends a line |
| out_data | output | PIX_W | Output pixel |

## Verification
The bench builds the compositor with a 48×27 screen and 16×9 tiles at x=8 and x=24, row 9. At that size every view can be compared pixel by pixel over whole frames in a short run. The tile edges, the full-screen second layer and the clamping of oversized and undersized layer-2 dimensions are all checked. At this size a chain of frames can also alternate views, with the select inputs changed mid-frame, and can run with random input gaps and output back-pressure.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int unsigned CW = 16;

  typedef enum logic [1:0] {
    VIEW_TILES  = 2'd0,
    VIEW_FIRST  = 2'd1,
    VIEW_SECOND = 2'd2
  } view_t;

  typedef struct packed {
    logic          shown;
    logic [CW-1:0] x0;
    logic [CW-1:0] y0;
    logic [CW-1:0] x1;
    logic [CW-1:0] y1;
  } rect_t;
endpackage

// File: rtl/comp_raster.sv
module comp_raster
  import comp_pkg::*;
#(
  parameter int unsigned SCR_W = 1920,
  parameter int unsigned SCR_H = 1080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] px,
  output logic [CW-1:0] py,
  output logic          at_origin,
  output logic          line_last,
  output logic          frame_last
);
  localparam logic [CW-1:0] XLAST = CW'(SCR_W - 1);
  localparam logic [CW-1:0] YLAST = CW'(SCR_H - 1);

  assign at_origin  = (px == '0) && (py == '0);
  assign line_last  = (px == XLAST);
  assign frame_last = line_last && (py == YLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      px <= '0;
      py <= '0;
    end else if (step) begin
      if (line_last) begin
        px <= '0;
        py <= (py == YLAST) ? '0 : py + 1'b1;
      end else begin
        px <= px + 1'b1;
      end
    end
  end

  // R1: a line ends by wrapping the column back to zero
  a_r1_eol_wrap: assert property (@(posedge clk) disable iff (rst)
    step && line_last |=> px == '0);
endmodule

// File: rtl/comp_view.sv
module comp_view
  import comp_pkg::*;
#(
  parameter int unsigned SCR_W   = 1920,
  parameter int unsigned SCR_H   = 1080,
  parameter int unsigned TILE_W  = 640,
  parameter int unsigned TILE_H  = 360,
  parameter int unsigned TILE1_X = 320,
  parameter int unsigned TILE2_X = 960,
  parameter int unsigned TILE_Y  = 360
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_open,
  input  logic          sel_single,
  input  logic          sel_pick2,
  input  logic [CW-1:0] l2_w,
  input  logic [CW-1:0] l2_h,
  output rect_t         rect_l1,
  output rect_t         rect_l2
);
  localparam logic [CW-1:0] SW  = CW'(SCR_W);
  localparam logic [CW-1:0] SH  = CW'(SCR_H);
  localparam logic [CW-1:0] T1A = CW'(TILE1_X);
  localparam logic [CW-1:0] T1B = CW'(TILE1_X + TILE_W);
  localparam logic [CW-1:0] T2A = CW'(TILE2_X);
  localparam logic [CW-1:0] T2B = CW'(TILE2_X + TILE_W);
  localparam logic [CW-1:0] TYA = CW'(TILE_Y);
  localparam logic [CW-1:0] TYB = CW'(TILE_Y + TILE_H);

  view_t         live_view, held_view, use_view;
  logic [CW-1:0] live_w, live_h, held_w, held_h, use_w, use_h;

  function automatic logic [CW-1:0] fit(input logic [CW-1:0] v, input logic [CW-1:0] lim);
    if (v == '0)     return CW'(1);
    else if (v > lim) return lim;
    else              return v;
  endfunction

  always_comb begin
    if (!sel_single)   live_view = VIEW_TILES;
    else if (sel_pick2) live_view = VIEW_SECOND;
    else               live_view = VIEW_FIRST;
    live_w = fit(l2_w, SW);
    live_h = fit(l2_h, SH);
  end

  // Capture while the raster sits on pixel (0,0); the last capture is the
  // cycle in which that pixel is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_view <= VIEW_TILES;
      held_w    <= SW;
      held_h    <= SH;
    end else if (frame_open) begin
      held_view <= live_view;
      held_w    <= live_w;
      held_h    <= live_h;
    end
  end

  assign use_view = frame_open ? live_view : held_view;
  assign use_w    = frame_open ? live_w    : held_w;
  assign use_h    = frame_open ? live_h    : held_h;

  always_comb begin
    rect_l1 = '{shown: 1'b0, x0: '0, y0: '0, x1: '0, y1: '0};
    rect_l2 = '{shown: 1'b0, x0: '0, y0: '0, x1: '0, y1: '0};
    unique case (use_view)
      VIEW_TILES: begin
        rect_l1 = '{shown: 1'b1, x0: T1A, y0: TYA, x1: T1B, y1: TYB};
        rect_l2 = '{shown: 1'b1, x0: T2A, y0: TYA, x1: T2B, y1: TYB};
      end
      VIEW_FIRST: begin
        rect_l1 = '{shown: 1'b1, x0: '0, y0: '0, x1: SW, y1: SH};
      end
      default: begin
        rect_l2 = '{shown: 1'b1, x0: '0, y0: '0, x1: use_w, y1: use_h};
      end
    endcase
  end
endmodule

// File: rtl/comp_layer_gate.sv
module comp_layer_gate
  import comp_pkg::*;
(
  input  rect_t         area,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          fire,
  output logic          in_ready,
  output logic          word_ok,
  output logic          covers
);
  logic first;

  assign covers = area.shown && (px >= area.x0) && (px < area.x1) &&
                  (py >= area.y0) && (py < area.y1);
  assign first  = covers && (px == area.x0) && (py == area.y0);

  always_comb begin
    if (!area.shown) begin
      in_ready = 1'b1;               // hidden layer: drain
      word_ok  = 1'b1;
    end else if (!covers) begin
      in_ready = 1'b0;
      word_ok  = 1'b1;
    end else if (first) begin
      word_ok  = in_valid && in_sof;
      in_ready = fire || (in_valid && !in_sof);  // drop until frame start
    end else begin
      word_ok  = in_valid;
      in_ready = fire;
    end
  end
endmodule

// File: rtl/view_compositor.sv
module view_compositor
  import comp_pkg::*;
#(
  parameter int unsigned SCR_W   = 1920,
  parameter int unsigned SCR_H   = 1080,
  parameter int unsigned TILE_W  = 640,
  parameter int unsigned TILE_H  = 360,
  parameter int unsigned TILE1_X = 320,
  parameter int unsigned TILE2_X = 960,
  parameter int unsigned TILE_Y  = 360,
  parameter int unsigned PIX_W   = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_single,
  input  logic             sel_pick2,
  input  logic [CW-1:0]    l2_width,
  input  logic [CW-1:0]    l2_height,
  input  logic             bg_valid,
  output logic             bg_ready,
  input  logic             bg_sof,
  input  logic [PIX_W-1:0] bg_data,
  input  logic             l1_valid,
  output logic             l1_ready,
  input  logic             l1_sof,
  input  logic [PIX_W-1:0] l1_data,
  input  logic             l2_valid,
  output logic             l2_ready,
  input  logic             l2_sof,
  input  logic [PIX_W-1:0] l2_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sof,
  output logic             out_eol,
  output logic [PIX_W-1:0] out_data
);
  localparam int unsigned NLAYER = 3;

  logic [CW-1:0]     px, py;
  logic              at_origin, line_last, frame_last, fire;
  rect_t             area [NLAYER];
  logic [NLAYER-1:0] vld, sof, rdy, ok, cov;
  logic [PIX_W-1:0]  pick;

  assign vld = {l2_valid, l1_valid, bg_valid};
  assign sof = {l2_sof, l1_sof, bg_sof};
  assign {l2_ready, l1_ready, bg_ready} = rdy;

  comp_raster #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_raster (
    .clk(clk), .rst(rst), .step(fire), .px(px), .py(py),
    .at_origin(at_origin), .line_last(line_last), .frame_last(frame_last)
  );

  comp_view #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .TILE_W(TILE_W), .TILE_H(TILE_H),
    .TILE1_X(TILE1_X), .TILE2_X(TILE2_X), .TILE_Y(TILE_Y)
  ) u_view (
    .clk(clk), .rst(rst), .frame_open(at_origin),
    .sel_single(sel_single), .sel_pick2(sel_pick2),
    .l2_w(l2_width), .l2_h(l2_height),
    .rect_l1(area[1]), .rect_l2(area[2])
  );

  assign area[0] = '{shown: 1'b1, x0: '0, y0: '0, x1: CW'(SCR_W), y1: CW'(SCR_H)};

  generate
    for (genvar g = 0; g < NLAYER; g++) begin : g_gate
      comp_layer_gate u_gate (
        .area(area[g]), .px(px), .py(py),
        .in_valid(vld[g]), .in_sof(sof[g]), .fire(fire),
        .in_ready(rdy[g]), .word_ok(ok[g]), .covers(cov[g])
      );
    end
  endgenerate

  assign fire = (&ok) && (!out_valid || out_ready);

  // Priority: layer 2, then layer 1, then background.
  always_comb begin
    if (cov[2])      pick = l2_data;
    else if (cov[1]) pick = l1_data;
    else             pick = bg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_sof   <= at_origin;
      out_eol   <= line_last;
      out_data  <= pick;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a refused output pixel stays presented unchanged
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  // R5: a shown video layer is only taken inside its rectangle
  a_r5_l1_inside: assert property (@(posedge clk) disable iff (rst)
    l1_valid && l1_ready && area[1].shown |-> cov[1]);
  a_r5_l2_inside: assert property (@(posedge clk) disable iff (rst)
    l2_valid && l2_ready && area[2].shown |-> cov[2]);

  // R1: the pixel taken at the origin leaves flagged as frame start
  a_r1_sof_origin: assert property (@(posedge clk) disable iff (rst)
    fire && at_origin |=> out_valid && out_sof);

  // R1: the last pixel of a frame also ends a line
  a_r1_last_eol: assert property (@(posedge clk) disable iff (rst)
    fire && frame_last |=> out_eol && !out_sof);
endmodule

// File: tb/view_compositor_bench.sv
module view_compositor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 48, H = 27, TW = 16, TH = 9, T1X = 8, T2X = 24, TY = 9;
  localparam int DRAIN_N = 50;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_single = 1'b0, sel_pick2 = 1'b0;
  logic [15:0] l2_width = 16'd0, l2_height = 16'd0;
  logic src_valid [3];
  logic src_sof [3];
  logic [23:0] src_data [3];
  logic rdy [3];
  logic bg_ready, l1_ready, l2_ready;
  logic out_valid, out_sof, out_eol;
  logic out_ready = 1'b0;
  logic [23:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit wd_hit = 1'b0;
  int sched_view [8];
  int sched_w [8];
  int sched_h [8];
  int garb_n [3][8];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdy[0] = bg_ready;
  assign rdy[1] = l1_ready;
  assign rdy[2] = l2_ready;

  view_compositor #(
    .SCR_W(W), .SCR_H(H), .TILE_W(TW), .TILE_H(TH),
    .TILE1_X(T1X), .TILE2_X(T2X), .TILE_Y(TY), .PIX_W(24)
  ) u_view_compositor (
    .clk(clk), .rst(rst), .sel_single(sel_single), .sel_pick2(sel_pick2),
    .l2_width(l2_width), .l2_height(l2_height),
    .bg_valid(src_valid[0]), .bg_ready(bg_ready), .bg_sof(src_sof[0]), .bg_data(src_data[0]),
    .l1_valid(src_valid[1]), .l1_ready(l1_ready), .l1_sof(src_sof[1]), .l1_data(src_data[1]),
    .l2_valid(src_valid[2]), .l2_ready(l2_ready), .l2_sof(src_sof[2]), .l2_data(src_data[2]),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_eol(out_eol), .out_data(out_data)
  );

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    wd_hit = 1'b1;
  end

  task automatic check(input bit good, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fit(input int v, input int lim);
    if (v == 0) return 1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic int src_len(input int L, input int f);
    int v = sched_view[f];
    if (L == 0) return W * H;
    if (L == 1) return (v == 0) ? TW * TH : ((v == 1) ? W * H : DRAIN_N);
    return (v == 0) ? TW * TH :
           ((v == 2) ? fit(sched_w[f], W) * fit(sched_h[f], H) : DRAIN_N);
  endfunction

  function automatic logic [23:0] exp_word(input int f, input int x, input int y);
    int v = sched_view[f];
    logic [23:0] bgw = {8'hB0, 16'(y * W + x)};
    if (v == 0) begin
      if (y >= TY && y < TY + TH && x >= T1X && x < T1X + TW)
        return {8'h11, 16'((y - TY) * TW + (x - T1X))};
      if (y >= TY && y < TY + TH && x >= T2X && x < T2X + TW)
        return {8'h22, 16'((y - TY) * TW + (x - T2X))};
      return bgw;
    end
    if (v == 1) return {8'h11, 16'(y * W + x)};
    if (x < fit(sched_w[f], W) && y < fit(sched_h[f], H))
      return {8'h22, 16'(y * fit(sched_w[f], W) + x)};
    return bgw;
  endfunction

  task automatic set_sel(input int f);
    sel_single = (sched_view[f] != 0);
    sel_pick2  = (sched_view[f] == 2);
    l2_width   = 16'(sched_w[f]);
    l2_height  = 16'(sched_h[f]);
  endtask

  task automatic clear_sched();
    for (int f = 0; f < 8; f++) begin
      sched_view[f] = 0; sched_w[f] = W; sched_h[f] = H;
      for (int L = 0; L < 3; L++) garb_n[L][f] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    for (int L = 0; L < 3; L++) begin
      src_valid[L] = 1'b0; src_sof[L] = 1'b0; src_data[L] = '0;
    end
    out_ready = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs nfr frames following the schedule and compares every pixel.
  task automatic run_schedule(input string tag, input int nfr, input bit gaps);
    int sf [3];
    int sp [3];
    bit hs [3];
    int done = 0, px = 0, fbad = 0, mark_bad = 0, hold_bad = 0;
    logic [23:0] fact = '0, fexp = '0, held = '0;
    bit hold_pend = 1'b0;
    for (int L = 0; L < 3; L++) begin sf[L] = 0; sp[L] = 0; hs[L] = 1'b0; end
    set_sel(0);
    do_reset();
    while (done < nfr && !wd_hit) begin
      @(negedge clk);
      for (int L = 0; L < 3; L++) begin
        if (hs[L]) begin
          sp[L]++;
          if (sp[L] == garb_n[L][sf[L]] + src_len(L, sf[L])) begin
            sf[L]++; sp[L] = 0;
          end
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int L = 0; L < 3; L++) begin
        if (sf[L] < nfr && sf[L] <= done) begin
          int g = garb_n[L][sf[L]];
          src_valid[L] = !(gaps && lfsr[L*3 +: 2] == 2'b00);
          if (sp[L] < g) begin
            src_data[L] = {8'hEE, 16'(sp[L])};
            src_sof[L]  = 1'b0;
          end else begin
            src_data[L] = {(L == 0) ? 8'hB0 : ((L == 1) ? 8'h11 : 8'h22), 16'(sp[L] - g)};
            src_sof[L]  = (sp[L] == g);
          end
        end else begin
          src_valid[L] = 1'b0; src_sof[L] = 1'b0;
        end
      end
      out_ready = !gaps || (lfsr[12:11] != 2'b00);
      #1;
      if (hold_pend && (!out_valid || out_data !== held)) hold_bad++;
      hold_pend = out_valid && !out_ready;
      held = out_data;
      for (int L = 0; L < 3; L++) hs[L] = src_valid[L] && rdy[L];
      if (out_valid && out_ready) begin
        logic [23:0] e = exp_word(done, px % W, px / W);
        if (out_data !== e) begin
          if (fbad == 0) begin fact = out_data; fexp = e; end
          fbad++;
        end
        if (out_sof !== (px == 0) || out_eol !== ((px % W) == W - 1)) mark_bad++;
        px++;
        if (px == (W * H) / 2 && done + 1 < nfr) set_sel(done + 1);
        if (px == W * H) begin
          check(fbad == 0, tag, $sformatf("frame %0d pixel data", done), int'(fact), int'(fexp));
          check(mark_bad == 0, "R1", $sformatf("frame %0d sof/eol marks wrong count", done), mark_bad, 0);
          if (sched_view[done] == 1)
            check(sf[2] > done, "R3", "layer 2 drained in first-layer view", sf[2], done + 1);
          if (sched_view[done] == 2)
            check(sf[1] > done, "R4", "layer 1 drained in second-layer view", sf[1], done + 1);
          done++; px = 0; fbad = 0; mark_bad = 0;
        end
      end
    end
    check(!wd_hit && done == nfr, tag, "frames completed", done, nfr);
    check(hold_bad == 0, "R8", "output changed while stalled", hold_bad, 0);
    @(negedge clk);
    for (int L = 0; L < 3; L++) src_valid[L] = 1'b0;
  endtask

  task automatic t_reset();
    clear_sched();
    set_sel(0);
    do_reset();
    rst = 1'b1;
    #1;
    check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    src_valid[1] = 1'b1; src_sof[1] = 1'b1;
    src_valid[2] = 1'b1; src_sof[2] = 1'b1;
    #1;
    check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(l1_ready === 1'b0, "R5", "l1_ready at (0,0) in tile view", l1_ready, 0);
    check(l2_ready === 1'b0, "R5", "l2_ready at (0,0) in tile view", l2_ready, 0);
    @(negedge clk);
    src_valid[1] = 1'b0; src_valid[2] = 1'b0;
  endtask

  task automatic t_tiles();
    clear_sched();
    run_schedule("R2 R5", 2, 1'b0);
  endtask

  task automatic t_first();
    clear_sched();
    sched_view[0] = 1; sched_view[1] = 1;
    run_schedule("R3", 2, 1'b0);
  endtask

  task automatic t_second();
    clear_sched();
    sched_view[0] = 2; sched_w[0] = W;  sched_h[0] = H;
    sched_view[1] = 2; sched_w[1] = 20; sched_h[1] = 10;
    sched_view[2] = 2; sched_w[2] = 60; sched_h[2] = 40;
    sched_view[3] = 2; sched_w[3] = 0;  sched_h[3] = 5;
    run_schedule("R4 R9", 4, 1'b0);
  endtask

  task automatic t_resync();
    clear_sched();
    sched_view[1] = 2; sched_w[1] = 20; sched_h[1] = 10;
    garb_n[0][0] = 3; garb_n[1][0] = 2; garb_n[2][0] = 1; garb_n[2][1] = 4;
    run_schedule("R6", 2, 1'b0);
  endtask

  task automatic t_stall();
    clear_sched();
    sched_view[1] = 1;
    sched_view[2] = 2; sched_w[2] = 30; sched_h[2] = 12;
    run_schedule("R8", 3, 1'b1);
  endtask

  task automatic t_switch();
    clear_sched();
    sched_view[0] = 1;
    sched_view[1] = 0;
    sched_view[2] = 2; sched_w[2] = 16; sched_h[2] = 20;
    sched_view[3] = 0;
    sched_view[4] = 1;
    run_schedule("R7", 5, 1'b0);
  endtask

  initial begin
    for (int L = 0; L < 3; L++) begin
      src_valid[L] = 1'b0; src_sof[L] = 1'b0; src_data[L] = '0;
    end
    t_reset();
    t_tiles();
    t_first();
    t_second();
    t_resync();
    t_stall();
    t_switch();
    if (wd_hit) check(1'b0, "R1", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule